// File: doc/BRIEF.md
# Reloadable Underflow Baud-Rate Timer

This block is an 8-bit down-counting timer that paces a serial interface. Software writes a reload value into a base register. It then raises a load bit in the mode register, which copies that value into the counter. Finally it drops load and raises enable. While running, the counter steps down once per count tick. At zero, the next tick copies the base value back into the counter and emits a one-cycle underflow strobe. The serial interface uses that strobe as its bit-timing reference. The strobe period is therefore (base + 1) count ticks.

Count ticks are synchronous enables in the system clock domain. A two-bit source select in the mode register picks one of four sources: the system clock divided by 4, the system clock divided by 16, rising edges of an external tick pin (synchronized first), or no tick at all. Changing the source select while the timer is loading or running spoils the count. The block then freezes in a halted state until software loads it again.

A four-state machine sequences the counter:
- STOP: idle and holding.
- LOAD: tracking the base register.
- RUN: counting.
- HALT: frozen after an illegal select change.

Its transitions are:
- any state enters LOAD while load is set. From HALT, this is the only way out.
- STOP, LOAD or RUN enter RUN when enable is set and load is clear.
- STOP, LOAD or RUN fall back to STOP when both bits are clear.
- any state enters HALT on a select change made while the old load or enable bit was set.

Top module: `rlt_baud_timer`

## Requirements
- R1: After reset, every register address reads 0x00 and `uflow` is low.
- R2: Register addresses are 0 = base (read/write), 1 = counter (read-only), 2 = mode, 3 = reads 0x00. The mode fields are: bit 7 enable, bit 6 load, bits 1:0 source select, bits 5:2 always read 0.
- R3: While the load bit is 1, the counter follows the base register within three cycles of a write. This holds whatever the enable bit is.
- R4: With enable and load both 0, the counter holds its value.
- R5: Source select 00 gives one count tick every 4 system cycles. While running, each tick lowers the counter by one.
- R6: A tick that finds the counter at zero reloads the base value and pulses `uflow`. With select 00 the pulse period is (base+1)*4 cycles, including base 0x00 and base 0xFF.
- R7: Source select 01 gives a pulse period of (base+1)*16 cycles.
- R8: Source select 10 counts each rising edge of `ext_tick` as one tick, so the period is (base+1) edges.
- R9: Source select 11 provides no ticks: the counter holds and `uflow` stays low while enabled.
- R10: Writing the base register during a run leaves the period in progress unchanged. The new value takes effect from the next reload.
- R11: A change of source select written while the old load or enable bit is 1 sends the timer to HALT. There the counter freezes and `uflow` stays low, even if enable is rewritten. Only a write with load = 1 leaves HALT.
- R12: Reads have no side effects, and writes to address 1 leave the counter unchanged.
- R13: `uflow` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| ext_tick | input | 1 | External tick source, asynchronous |
| uflow | output | 1 | One-cycle underflow strobe to the serial interface |

## Verification
The bench measures the spacing between strobes rather than single counter values. It targets the extremes base 0x00 and 0xFF, where an off-by-one in the reload or the zero test would give periods of 0 or 256 ticks. A base rewrite in mid-period catches a design that reloads immediately, because the running period would then come out shorter than expected. An illegal select change followed by a bare enable rewrite catches a design that resumes counting without a reload. Set load and enable together to catch a design that gives enable priority, since that counter would run instead of tracking the base.

// File: rtl/rlt_pkg.sv
package rlt_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } tmr_state_e;

    localparam logic [1:0] ADDR_BASE = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_MODE = 2'd2;

    localparam logic [1:0] SRC_DIV_A = 2'd0;
    localparam logic [1:0] SRC_DIV_B = 2'd1;
    localparam logic [1:0] SRC_EXT   = 2'd2;
    localparam logic [1:0] SRC_NONE  = 2'd3;

endpackage

// File: rtl/rlt_prescaler.sv
module rlt_prescaler
    import rlt_pkg::*;
#(
    parameter int DIV_A_LOG2  = 2,
    parameter int DIV_B_LOG2  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       ext_tick,
    output logic       count_tick
);
    localparam int PW = (DIV_B_LOG2 > DIV_A_LOG2) ? DIV_B_LOG2 : DIV_A_LOG2;

    logic [PW-1:0]        pre_q;
    logic [SYNC_STAGES:0] sync_q;
    logic                 tick_a;
    logic                 tick_b;
    logic                 tick_ext;

    // Free-running divider shared by both internal sources
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + PW'(1);
    end

    assign tick_a = &pre_q[DIV_A_LOG2-1:0];
    assign tick_b = &pre_q[DIV_B_LOG2-1:0];

    // Synchronizer chain for the external source, one extra stage for edge detect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_tick;
    end

    genvar gi;
    generate
        for (gi = 1; gi <= SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[gi] <= 1'b0;
                else        sync_q[gi] <= sync_q[gi-1];
            end
        end
    endgenerate

    assign tick_ext = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

    always_comb begin
        unique case (src_sel)
            SRC_DIV_A: count_tick = tick_a;
            SRC_DIV_B: count_tick = tick_b;
            SRC_EXT:   count_tick = tick_ext;
            SRC_NONE:  count_tick = 1'b0;
        endcase
    end

    // R5: the fast internal source never fires on adjacent cycles
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_a |=> !tick_a);

    // R8: an external edge yields an isolated one-cycle tick
    p_ext_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_ext |=> !tick_ext);

endmodule

// File: rtl/rlt_regs.sv
module rlt_regs
    import rlt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] cnt_i,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] base_o,
    output logic          en_o,
    output logic          ld_o,
    output logic [1:0]    sel_o,
    output logic          spoil_o
);
    localparam int EN_POS = DW - 1;
    localparam int LD_POS = DW - 2;
    localparam int PADW   = DW - 4;

    logic [DW-1:0] base_q;
    logic          en_q;
    logic          ld_q;
    logic [1:0]    sel_q;
    logic          spoil_q;
    logic          wr_base;
    logic          wr_mode;

    assign wr_base = reg_wr && (reg_addr == ADDR_BASE);
    assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else if (wr_base) base_q <= reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            ld_q    <= 1'b0;
            sel_q   <= SRC_DIV_A;
            spoil_q <= 1'b0;
        end else begin
            spoil_q <= 1'b0;
            if (wr_mode) begin
                en_q    <= reg_wdata[EN_POS];
                ld_q    <= reg_wdata[LD_POS];
                sel_q   <= reg_wdata[1:0];
                spoil_q <= (en_q || ld_q) && (reg_wdata[1:0] != sel_q);
            end
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_BASE: reg_rdata = base_q;
            ADDR_CNT:  reg_rdata = cnt_i;
            ADDR_MODE: reg_rdata = {en_q, ld_q, {PADW{1'b0}}, sel_q};
            default:   reg_rdata = '0;
        endcase
    end

    assign base_o  = base_q;
    assign en_o    = en_q;
    assign ld_o    = ld_q;
    assign sel_o   = sel_q;
    assign spoil_o = spoil_q;

    // R11: a spoil flag only follows a mode where counting was active
    p_spoil_needs_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spoil_q |-> $past(en_q || ld_q));

    // R2: the source select moves only on a mode write
    p_sel_write_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_mode) |-> $stable(sel_q));

endmodule

// File: rtl/rlt_counter.sv
module rlt_counter
    import rlt_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          ld_i,
    input  logic          spoil_i,
    input  logic [CW-1:0] base_i,
    output logic [CW-1:0] cnt_o,
    output logic          uflow_o
);
    tmr_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          uf_q, uf_d;

    always_comb begin
        if (spoil_i) begin
            st_d = ST_HALT;
        end else begin
            unique case (st_q)
                ST_HALT: st_d = ld_i ? ST_LOAD : ST_HALT;
                ST_STOP: st_d = ld_i ? ST_LOAD : (en_i ? ST_RUN : ST_STOP);
                ST_LOAD: st_d = ld_i ? ST_LOAD : (en_i ? ST_RUN : ST_STOP);
                ST_RUN:  st_d = ld_i ? ST_LOAD : (en_i ? ST_RUN : ST_STOP);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    always_comb begin
        cnt_d = cnt_q;
        uf_d  = 1'b0;
        unique case (st_q)
            ST_STOP: cnt_d = cnt_q;
            ST_HALT: cnt_d = cnt_q;
            ST_LOAD: cnt_d = base_i;
            ST_RUN: begin
                if (tick_i) begin
                    if (cnt_q == '0) begin
                        cnt_d = base_i;
                        uf_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            uf_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            uf_q  <= uf_d;
        end
    end

    assign cnt_o   = cnt_q;
    assign uflow_o = uf_q;

    p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP) |=> (cnt_q == $past(cnt_q)));

    p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HALT) |=> ((cnt_q == $past(cnt_q)) && !uf_q));

    p_run_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RUN) && !tick_i) |=> $stable(cnt_q));

    p_uflow_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |-> (cnt_q == $past(base_i)));

    p_uflow_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        uf_q |=> !uf_q);

endmodule

// File: rtl/rlt_baud_timer.sv
module rlt_baud_timer
    import rlt_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_A_LOG2  = 2,
    parameter int DIV_B_LOG2  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ext_tick,
    output logic          uflow
);
    logic [DW-1:0] base;
    logic [DW-1:0] cnt;
    logic          en;
    logic          ld;
    logic [1:0]    sel;
    logic          spoil;
    logic          tick;

    rlt_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt_i     (cnt),
        .reg_rdata (reg_rdata),
        .base_o    (base),
        .en_o      (en),
        .ld_o      (ld),
        .sel_o     (sel),
        .spoil_o   (spoil)
    );

    rlt_prescaler #(
        .DIV_A_LOG2  (DIV_A_LOG2),
        .DIV_B_LOG2  (DIV_B_LOG2),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (sel),
        .ext_tick   (ext_tick),
        .count_tick (tick)
    );

    rlt_counter #(.CW(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .en_i    (en),
        .ld_i    (ld),
        .spoil_i (spoil),
        .base_i  (base),
        .cnt_o   (cnt),
        .uflow_o (uflow)
    );

endmodule

// File: tb/rlt_baud_timer_tb.sv
module rlt_baud_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_tick = 1'b0;
    logic       uflow;

    int  nvec = 0, nfail = 0;
    int  cyc = 0, uf_cnt = 0, last_uf = 0, prev_uf = 0, wide_err = 0;
    bit  uf_prev_s = 1'b0, ext_run = 1'b0, done = 1'b0;

    rlt_baud_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_tick(ext_tick), .uflow(uflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (uflow) begin
            prev_uf = last_uf;
            last_uf = cyc;
            uf_cnt  = uf_cnt + 1;
            if (uf_prev_s) wide_err = wide_err + 1;
        end
        uf_prev_s = uflow;
    end

    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (ext_run) begin
                ph = ph + 1;
                ext_tick = ((ph % 6) < 3);
            end else begin
                ext_tick = 1'b0;
            end
        end
    end

    function automatic int exp_period(input int b, input int s);
        case (s)
            0: return (b + 1) * 4;
            1: return (b + 1) * 16;
            2: return (b + 1) * 6;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec = nvec + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_uf(input int target, input string req);
        int g;
        g = 0;
        while (uf_cnt < target && g < 6000) begin
            @(posedge clk);
            g = g + 1;
        end
        if (uf_cnt < target) chk(req, uf_cnt, target);
    endtask

    task automatic start(input logic [7:0] b, input logic [1:0] s);
        wr(2'd0, b);
        wr(2'd2, {2'b01, 4'b0, s});
        repeat (3) @(negedge clk);
        wr(2'd2, {2'b10, 4'b0, s});
    endtask

    task automatic stop(input logic [1:0] s);
        wr(2'd2, {6'b0, s});
        repeat (3) @(negedge clk);
    endtask

    task automatic period_check(input int b, input int s, input string req);
        int st;
        st = uf_cnt;
        wait_uf(st + 2, req);
        chk(req, last_uf - prev_uf, exp_period(b, s));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail = nfail + 1;
            nvec  = nvec + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, v2;
        int s0, ta, b, s;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R1 reg reset", v, 0);
        end
        chk("R1 uflow low", uflow, 0);

        // R2 mode layout and padding
        wr(2'd2, 8'hFF);
        rd(2'd2, v); chk("R2 mode readback", v, 8'hC3);
        wr(2'd2, 8'h03);
        wr(2'd2, 8'h00);
        rd(2'd3, v); chk("R2 addr3 zero", v, 0);
        rd(2'd2, v); chk("R2 mode cleared", v, 0);

        // R3 load tracks base, priority over enable
        wr(2'd0, 8'h26);
        wr(2'd2, 8'hC0);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R3 load copy", v, 8'h26);
        wr(2'd0, 8'h11);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R3 load follows base", v, 8'h11);
        stop(2'd0);

        // R4 hold and R12 no-side-effect reads, ignored counter writes
        repeat (50) @(negedge clk);
        rd(2'd1, v); chk("R4 stopped hold", v, 8'h11);
        wr(2'd1, 8'h55);
        rd(2'd1, v); chk("R12 counter write ignored", v, 8'h11);
        rd(2'd1, v2); chk("R12 read repeat", v2, v);

        // R5 stepping, R6 period
        start(8'h26, 2'd0);
        for (int k = 0; k < 3; k++) begin
            rd(2'd1, v);
            repeat (3) @(negedge clk);
            rd(2'd1, v2);
            chk("R5 decrement", v2, (v == 0) ? 8'h26 : v - 1);
        end
        period_check(8'h26, 0, "R6 period div4");

        // R10 base write mid-period
        s0 = uf_cnt;
        wait_uf(s0 + 1, "R10 wait");
        ta = last_uf;
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h05);
        wait_uf(s0 + 2, "R10 wait");
        chk("R10 current period kept", last_uf - ta, exp_period(8'h26, 0));
        wait_uf(s0 + 3, "R10 wait");
        chk("R10 new base applied", last_uf - prev_uf, exp_period(5, 0));
        stop(2'd0);

        // R7 div16
        start(8'h09, 2'd1);
        period_check(9, 1, "R7 period div16");
        stop(2'd1);

        // R8 external edges
        ext_run = 1'b1;
        start(8'h03, 2'd2);
        period_check(3, 2, "R8 period ext");
        stop(2'd2);
        ext_run = 1'b0;

        // R9 no source
        start(8'h05, 2'd3);
        s0 = uf_cnt;
        repeat (100) @(negedge clk);
        rd(2'd1, v); chk("R9 counter holds", v, 5);
        chk("R9 no uflow", uf_cnt - s0, 0);
        stop(2'd3);

        // R11 illegal select change
        start(8'h20, 2'd0);
        repeat (20) @(negedge clk);
        wr(2'd2, 8'h81);
        repeat (5) @(negedge clk);
        rd(2'd1, v);
        s0 = uf_cnt;
        wr(2'd2, 8'h01);
        wr(2'd2, 8'h81);
        repeat (200) @(negedge clk);
        rd(2'd1, v2); chk("R11 halt frozen", v2, v);
        chk("R11 halt no uflow", uf_cnt - s0, 0);
        wr(2'd2, 8'h41);
        repeat (3) @(negedge clk);
        rd(2'd1, v); chk("R11 reload exits halt", v, 8'h20);
        wr(2'd2, 8'h81);
        period_check(8'h20, 1, "R11 resumed period");
        stop(2'd1);

        // R6 extremes
        start(8'h00, 2'd0);
        period_check(0, 0, "R6 base zero");
        stop(2'd0);
        start(8'hFF, 2'd0);
        period_check(255, 0, "R6 base max");
        stop(2'd0);

        // random mix
        for (int it = 0; it < 16; it++) begin
            b = $urandom_range(0, 40);
            s = $urandom_range(0, 1);
            start(b[7:0], s[1:0]);
            period_check(b, s, s == 0 ? "R6 random" : "R7 random");
            stop(s[1:0]);
        end

        chk("R13 single-cycle uflow", wide_err, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule